// File: doc/BRIEF.md
# Parallel Halfword Checksum Accelerator

This block sits on the transmit path between a FIFO and a downstream checksum engine. Each data beat normally hands over one 16-bit halfword. When the engine reports that it has entered its per-byte summing loop, the block can add up to four halfwords of the current 64-bit FIFO word in one clock. It then presents that sum in place of the raw halfword, together with two carry bits and the number of frame bytes the sum covers. The engine folds the carries into its ones'-complement total and steps its remaining-byte count down by the reported amount. The final fold is the engine's job, not this block's.

The block keeps a 16-bit frame position counter that a start-of-frame pulse clears. The counter moves forward by the bytes each beat delivers. The block only engages on an 8-byte boundary of that counter, and only while at least three bytes remain. When the remaining count lies between 3 and 7, the bytes past that count are treated as zero in the sum. All outputs are registered, so a beat's result appears one clock after the beat.

Top module: `ckacc_top`

## Requirements
- R1: While reset is held and just after it, `out_valid_o` is 0, `out_accel_o` is 0 and `frame_cnt_o` is 0.
- R2: A beat is summed only if all three hold: `loop_i` is 1, the low three bits of the frame count are zero, and `remain_i` is at least 3. Its result appears on the outputs one clock after the beat, with `out_accel_o`=1.
- R3: A summed beat outputs the 18-bit sum of the four halfwords of `data_i`. Halfword h is `data_i[63-16h -: 16]`, and the carry of the sum lands in bits 17:16.
- R4: On a summed beat, `out_bytes_o` equals `remain_i` when that is below 8, and 8 otherwise.
- R5: On a summed beat covering n < 8 bytes, every byte k ≥ n is zero in the sum. Byte k is `data_i[63-8k -: 8]`, and a halfword takes its first byte in the upper position.
- R6: An unsummed beat outputs halfword 0 (`data_i[63:48]`) in bits 15:0, zero carry bits, `out_bytes_o`=2 and `out_accel_o`=0.
- R7: When `remain_i` is below 3, a beat is passed raw even though the count is aligned and `loop_i` is 1.
- R8: After every beat, `frame_cnt_o` goes up by that beat's byte count. It wraps modulo 65536.
- R9: A `sof_i` pulse clears the frame count. If a beat arrives in the same cycle, that beat is judged against a count of zero, and the new count equals its byte count.
- R10: In a cycle with no beat, `out_valid_o` is 0 in the next cycle. If `sof_i` is also low, `frame_cnt_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame pulse, clears the frame count |
| loop_i | input | 1 | Engine is in its summing loop |
| remain_i | input | 16 | Bytes the engine still has to process |
| beat_i | input | 1 | A data beat is presented this cycle |
| data_i | input | 64 | FIFO word, four halfwords, first byte at the top |
| out_valid_o | output | 1 | Registered result is valid |
| out_accel_o | output | 1 | Result is a multi-halfword sum |
| out_data_o | output | 18 | Sum with carries in 17:16, or the raw halfword |
| out_bytes_o | output | 4 | Frame bytes covered by the result |
| frame_cnt_o | output | 16 | Frame byte position counter |

## Verification
The tricky overlap is a start-of-frame pulse arriving in the same cycle as a data beat. The clear must take effect before the alignment test, so a frame that begins mid-group engages at once when the engine loop is active. The bench provokes this directly: it raises both inputs together on an unaligned count, with `remain_i` both above and below three. Random runs also raise the pulse on about one beat in sixteen. The bench model applies the clear first and then the increment. It compares the engaged flag, the byte count, the sum and the new counter value after each such beat.

// File: rtl/ckacc_pkg.sv
package ckacc_pkg;

    typedef enum logic {
        PATH_RAW = 1'b0,
        PATH_SUM = 1'b1
    } path_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ckacc_gate.sv
module ckacc_gate
    import ckacc_pkg::*;
#(
    parameter int HW_W      = 16,
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int MIN_BYTES = 3,
    localparam int GRP_B    = LANES * HW_W / BYTE_W,
    localparam int BC_W     = $clog2(GRP_B + 1),
    localparam int ALIGN_W  = $clog2(GRP_B)
) (
    input  logic             loop_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] remain_i,
    output path_e            path_o,
    output logic [BC_W-1:0]  bytes_o
);

    localparam int HB = HW_W / BYTE_W;

    logic aligned;
    logic enough;

    always_comb begin
        aligned = (cnt_i[ALIGN_W-1:0] == '0);
        enough  = (remain_i >= CNT_W'(MIN_BYTES));
        if (loop_i && aligned && enough) begin
            path_o = PATH_SUM;
            if (remain_i >= CNT_W'(GRP_B)) begin
                bytes_o = BC_W'(GRP_B);
            end else begin
                bytes_o = remain_i[BC_W-1:0];
            end
        end else begin
            path_o  = PATH_RAW;
            bytes_o = BC_W'(HB);
        end
    end

endmodule

// File: rtl/ckacc_sum.sv
module ckacc_sum
    import ckacc_pkg::*;
#(
    parameter int HW_W     = 16,
    parameter int LANES    = 4,
    localparam int GRP_B   = LANES * HW_W / BYTE_W,
    localparam int BC_W    = $clog2(GRP_B + 1),
    localparam int SUM_W   = HW_W + $clog2(LANES),
    localparam int DATA_W  = LANES * HW_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [BC_W-1:0]   bytes_i,
    output logic [SUM_W-1:0]  sum_o
);

    logic [DATA_W-1:0] masked;

    generate
        for (genvar k = 0; k < GRP_B; k++) begin : g_byte
            assign masked[DATA_W-1-BYTE_W*k -: BYTE_W] =
                (BC_W'(k) < bytes_i) ? data_i[DATA_W-1-BYTE_W*k -: BYTE_W] : '0;
        end
    endgenerate

    always_comb begin
        sum_o = '0;
        for (int h = 0; h < LANES; h++) begin
            sum_o = sum_o + SUM_W'(masked[DATA_W-1-HW_W*h -: HW_W]);
        end
    end

endmodule

// File: rtl/ckacc_top.sv
module ckacc_top
    import ckacc_pkg::*;
#(
    parameter int HW_W      = 16,
    parameter int LANES     = 4,
    parameter int CNT_W     = 16,
    parameter int MIN_BYTES = 3,
    localparam int GRP_B    = LANES * HW_W / BYTE_W,
    localparam int BC_W     = $clog2(GRP_B + 1),
    localparam int SUM_W    = HW_W + $clog2(LANES),
    localparam int DATA_W   = LANES * HW_W,
    localparam int ALIGN_W  = $clog2(GRP_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              loop_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic              beat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              out_valid_o,
    output logic              out_accel_o,
    output logic [SUM_W-1:0]  out_data_o,
    output logic [BC_W-1:0]   out_bytes_o,
    output logic [CNT_W-1:0]  frame_cnt_o
);

    localparam int HB = HW_W / BYTE_W;

    typedef struct packed {
        logic             vld;
        path_e            path;
        logic [SUM_W-1:0] data;
        logic [BC_W-1:0]  bytes;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] eff_cnt_d;
    path_e            path_d;
    logic [BC_W-1:0]  bytes_d;
    logic [SUM_W-1:0] sum_d;

    assign eff_cnt_d = sof_i ? '0 : st_q.cnt;

    ckacc_gate #(
        .HW_W      (HW_W),
        .LANES     (LANES),
        .CNT_W     (CNT_W),
        .MIN_BYTES (MIN_BYTES)
    ) u_gate (
        .loop_i   (loop_i),
        .cnt_i    (eff_cnt_d),
        .remain_i (remain_i),
        .path_o   (path_d),
        .bytes_o  (bytes_d)
    );

    ckacc_sum #(
        .HW_W  (HW_W),
        .LANES (LANES)
    ) u_sum (
        .data_i  (data_i),
        .bytes_i (bytes_d),
        .sum_o   (sum_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = beat_i;
        st_d.path = PATH_RAW;
        st_d.cnt  = eff_cnt_d;
        if (beat_i) begin
            st_d.path  = path_d;
            st_d.bytes = bytes_d;
            if (path_d == PATH_SUM) begin
                st_d.data = sum_d;
            end else begin
                st_d.data = SUM_W'(data_i[DATA_W-1 -: HW_W]);
            end
            st_d.cnt = eff_cnt_d + CNT_W'(bytes_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bytes <= BC_W'(HB);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign out_accel_o = (st_q.path == PATH_SUM);
    assign out_data_o  = st_q.data;
    assign out_bytes_o = st_q.bytes;
    assign frame_cnt_o = st_q.cnt;

    // R6: a raw result carries no carry bits and covers one halfword
    p_raw_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_accel_o |->
            out_data_o[SUM_W-1:HW_W] == '0 && out_bytes_o == BC_W'(HB));

    // R4: summed byte counts stay within the legal window
    p_bytes_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_accel_o |->
            out_bytes_o >= BC_W'(MIN_BYTES) && out_bytes_o <= BC_W'(GRP_B));

    // R2: summing only starts from an aligned count or a fresh frame
    p_aligned_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_accel_o |->
            $past(sof_i) || $past(frame_cnt_o[ALIGN_W-1:0]) == '0);

    // R7: too few remaining bytes never yields a sum
    p_short_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i && remain_i < CNT_W'(MIN_BYTES) |=> !out_accel_o);

    // R10: idle cycle gives no valid and a steady counter
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_i && !sof_i |=> !out_valid_o && $stable(frame_cnt_o));

    // R9: a lone start-of-frame pulse zeroes the counter
    p_sof_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i && !beat_i |=> frame_cnt_o == '0);

endmodule

// File: tb/sim_ckacc_top.sv
module sim_ckacc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof_i, loop_i, beat_i;
    logic [15:0] remain_i;
    logic [63:0] data_i;
    logic        out_valid_o, out_accel_o;
    logic [17:0] out_data_o;
    logic [3:0]  out_bytes_o;
    logic [15:0] frame_cnt_o;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [15:0] m_cnt  = '0;
    bit          done   = 1'b0;

    always #2 clk = ~clk;

    ckacc_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .loop_i      (loop_i),
        .remain_i    (remain_i),
        .beat_i      (beat_i),
        .data_i      (data_i),
        .out_valid_o (out_valid_o),
        .out_accel_o (out_accel_o),
        .out_data_o  (out_data_o),
        .out_bytes_o (out_bytes_o),
        .frame_cnt_o (frame_cnt_o)
    );

    function automatic logic [17:0] exp_sum(logic [63:0] d, int nb);
        logic [63:0] m;
        logic [17:0] s;
        m = d;
        for (int k = 0; k < 8; k++) begin
            if (k >= nb) m[63-8*k -: 8] = 8'h00;
        end
        s = '0;
        for (int h = 0; h < 4; h++) s = s + 18'(m[63-16*h -: 16]);
        return s;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive at negedge, compare one clock later just after posedge
    task automatic step(string tag, bit sof, bit lp, logic [15:0] rem, bit bt, logic [63:0] d);
        logic [15:0] eff;
        bit          eng;
        int          nb;
        logic [17:0] ed;
        string       t;
        sof_i = sof; loop_i = lp; remain_i = rem; beat_i = bt; data_i = d;
        eff = sof ? 16'h0 : m_cnt;
        eng = lp && (eff[2:0] == 3'b000) && (rem >= 16'd3);
        nb  = eng ? ((rem >= 16'd8) ? 8 : int'(rem)) : 2;
        ed  = eng ? exp_sum(d, nb) : 18'(d[63:48]);
        t = tag;
        if (t == "") begin
            if (!bt) t = "R10";
            else if (sof) t = "R9";
            else if (eng && nb < 8) t = "R5";
            else if (eng) t = "R3";
            else if (lp && eff[2:0] == 3'b000) t = "R7";
            else t = "R6";
        end
        m_cnt = bt ? eff + 16'(nb) : eff;
        @(posedge clk);
        #1;
        chk(t, "valid", 32'(out_valid_o), 32'(bt));
        if (bt) begin
            chk(t, "accel", 32'(out_accel_o), 32'(eng));
            chk(t, "data",  32'(out_data_o),  32'(ed));
            chk(eng ? "R4" : t, "bytes", 32'(out_bytes_o), 32'(nb));
        end
        chk(bt ? "R8" : t, "frame_cnt", 32'(frame_cnt_o), 32'(m_cnt));
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sof_i = 0; loop_i = 0; remain_i = '0; beat_i = 0; data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid in reset", 32'(out_valid_o), 32'd0);
        chk("R1", "cnt in reset", 32'(frame_cnt_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "accel after reset", 32'(out_accel_o), 32'd0);
        @(negedge clk);

        // R6 raw halfword with loop idle
        step("R6", 0, 0, 16'd100, 1, 64'h1234_5678_9abc_def0);
        for (int i = 0; i < 3; i++) step("R6", 0, 0, 16'd100, 1, 64'hfeed_0000_0000_0001);
        // R3 aligned full group, all ones -> carries set
        step("R3", 0, 1, 16'd100, 1, 64'hffff_ffff_ffff_ffff);
        // R5 partial group of five bytes
        step("R5", 0, 1, 16'd5, 1, 64'hffff_ffff_ffff_ffff);
        // R2 unaligned count refuses to sum
        step("R2", 0, 1, 16'd100, 1, 64'h0102_0304_0506_0708);
        // R7 with R9: fresh frame aligned but only two bytes left
        step("R7", 1, 1, 16'd2, 1, 64'haaaa_bbbb_cccc_dddd);
        // R9 same-cycle pulse on unaligned count engages at once
        step("R9", 1, 1, 16'd7, 1, 64'h8000_8000_8000_8000);
        step("R9", 1, 0, 16'd0, 0, 64'h0);
        step("R10", 0, 1, 16'd50, 0, 64'hdead_beef_dead_beef);
        // R8 wrap: 8192 full groups of 8 bytes
        for (int i = 0; i < 8192; i++) step("R8", 0, 1, 16'd1000, 1, {$urandom, $urandom});
        chk("R8", "wrapped cnt", 32'(frame_cnt_o), 32'd0);

        for (int i = 0; i < 3000; i++) begin
            bit          s  = ($urandom % 16) == 0;
            bit          lp = ($urandom % 4) != 0;
            bit          bt = ($urandom % 8) != 0;
            logic [15:0] r  = (($urandom % 2) == 0) ? 16'($urandom % 10) : 16'($urandom);
            step("", s, lp, r, bt, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule